// File: doc/BRIEF.md
# Blanking-Synchronised Shadow Register Update

This block holds a bank of colour-space-conversion coefficients and a small packet-content store. Each value exists twice: a shadow copy that the host writes and an active copy that the video datapath uses. The host raises a lock bit, edits as many shadow values as it needs, and drops the lock again. The block then waits for the next rising edge of the vertical blanking input and copies every shadow value into the active copies on that one clock edge. The datapath therefore never sees a half-edited coefficient set or packet. A 2-bit scaling field sits outside this scheme, and host writes to it reach the output at once.

The packet store has one shared shadow memory. The host claims it for one packet slot at a time. A claim is refused while a different slot holds the memory or still has a transfer waiting, and a busy flag records the refusal. Reads return shadow values while the relevant lock is held and active values otherwise. This lets software check its edits before it commits them.

Top module: `blank_sync_shadow`

## Requirements
- R1: After synchronous reset every active coefficient, every active packet byte, the scaling field, the lock, the busy flag and all readback values are 0, and no packet slot holds the shared memory.
- R2: A write to coefficient address 0x10+i (i below the coefficient count, value taken from the low COEF_W data bits) changes only the shadow copy. The active copy keeps its old value until a transfer.
- R3: Active coefficients change only on the clock edge at which vblank is sampled 1 after being sampled 0 on the previous edge (a vblank rise).
- R4: Writing 0 to the lock bit (bit 0 of address 0x00) while it is 1 arms a transfer. On the first vblank rise after the lock register reads 0, all coefficients take their shadow values on the same edge.
- R5: If the lock is set again before an armed transfer takes place, the transfer is held and no coefficient changes. It takes place at the first vblank rise after the lock is cleared once more.
- R6: The scaling field (bits 2:1 of address 0x00) drives the scale output from the clock edge of the write, whether the lock is set or not.
- R7: A write to address 0x01 with bit 7 set claims packet slot bits[1:0]. The claim is accepted when no slot holds the memory. It is refused when a different slot holds it or is waiting for transfer. A refusal sets the busy flag (output pkt_busy and bit 6 of 0x01), and any other write to 0x01 clears it. Readback of 0x01 gives bit 7 = held, bit 5 = transfer waiting, bits[1:0] = selected slot.
- R8: Writes to packet byte address 0x80+b reach the shared shadow only while a slot holds it and are ignored otherwise. After a release (write to 0x01 with bit 7 clear), the held slot's active bytes all take the shadow values at the next vblank rise.
- R9: Reading a coefficient returns its shadow value while the lock is 1 and its active value otherwise. Reading a packet byte returns the shared shadow while a slot holds it and the selected slot's active byte otherwise. A claim loads the shadow from that slot's active bytes.
- R10: A coefficient write made while the lock is 0 also waits for the next vblank rise before it reaches the active copy. Bit 3 of 0x00 reads 1 while a transfer is armed.
- R11: Claiming again the same slot while its transfer is waiting cancels the transfer and holds the memory again. The shadow edits are kept for the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| vblank | input | 1 | Vertical blanking level |
| coef_active | output | NUM_COEF*COEF_W | Active coefficients, index i at bits i*COEF_W |
| csc_scale | output | 2 | Scaling field, not shadowed |
| pkt_active | output | PKT_SLOTS*PKT_BYTES*8 | Active packet bytes, slot s byte b at bits (s*PKT_BYTES+b)*8 |
| pkt_busy | output | 1 | Last packet claim was refused |

## Verification
The scale output, the busy flag and every control readback bit change on the clock edge that takes the write, so they are due one edge after the write is presented. Active coefficients and packet bytes change on the edge where vblank is first sampled high, and they are visible right after that edge. rd_data follows rd_addr with no clock. The bench drives all inputs and samples all outputs on the falling edge. Its reference model steps on the rising edge from the same sampled inputs, so each comparison refers to exactly one edge. The directed checks place each vblank pulse after the writes they commit, so they cover both the cycle before the transfer and the cycle after it.

// File: rtl/bss_pkg.sv
package bss_pkg;
   typedef enum logic [1:0] {
      PK_IDLE = 2'd0,
      PK_HELD = 2'd1,
      PK_WAIT = 2'd2
   } pkt_state_e;

   localparam int CTL_LOCK_BIT = 0;
   localparam int CTL_SCALE_LO = 1;
   localparam int CTL_PEND_BIT = 3;
   localparam int PKC_REQ_BIT  = 7;
   localparam int PKC_BUSY_BIT = 6;
   localparam int PKC_WAIT_BIT = 5;
endpackage

// File: rtl/bss_vblank_edge.sv
module bss_vblank_edge (
   input  logic clk,
   input  logic rst,
   input  logic vblank,
   output logic vb_rise
);
   logic vb_q;

   always_ff @(posedge clk) begin
      if (rst) vb_q <= 1'b0;
      else     vb_q <= vblank;
   end

   assign vb_rise = vblank & ~vb_q;
endmodule

// File: rtl/bss_coef_bank.sv
module bss_coef_bank #(
   parameter int NUM   = 12,
   parameter int W     = 13,
   parameter int IDX_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_hit,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [W-1:0]       wr_val,
   input  logic               xfer,
   output logic [NUM*W-1:0]   shadow_flat,
   output logic [NUM*W-1:0]   active_flat
);
   initial begin
      assert (NUM >= 2 && (1 << IDX_W) >= NUM)
         else $fatal(1, "coef bank index width too small");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_coef
      logic [W-1:0] sh_q;
      logic [W-1:0] ac_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            sh_q <= '0;
            ac_q <= '0;
         end else begin
            if (xfer) ac_q <= sh_q;
            if (wr_hit && wr_idx == IDX_W'(g)) sh_q <= wr_val;
         end
      end

      assign shadow_flat[g*W +: W] = sh_q;
      assign active_flat[g*W +: W] = ac_q;
   end
endmodule

// File: rtl/bss_pkt_store.sv
module bss_pkt_store
   import bss_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int BYTES  = 8,
   parameter int SIDX_W = 2,
   parameter int BOFF_W = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    vb_rise,
   input  logic                    ctl_wr,
   input  logic                    ctl_req,
   input  logic [SIDX_W-1:0]       ctl_idx,
   input  logic                    byte_wr,
   input  logic [BOFF_W-1:0]       byte_off,
   input  logic [7:0]              byte_val,
   output logic [SLOTS*BYTES*8-1:0] active_flat,
   output logic [BYTES*8-1:0]      shadow_flat,
   output pkt_state_e              state,
   output logic [SIDX_W-1:0]       sel,
   output logic                    busy
);
   pkt_state_e        st_q, st_d;
   logic [SIDX_W-1:0] sel_q, sel_d;
   logic              busy_q, busy_d;
   logic              load, same_slot, cancel, pxfer;
   logic [7:0]        act_q [SLOTS][BYTES];
   logic [7:0]        sh_q  [BYTES];

   initial begin
      assert (SLOTS >= 2 && (1 << SIDX_W) >= SLOTS && (1 << BOFF_W) >= BYTES)
         else $fatal(1, "packet store widths inconsistent");
   end

   always_comb begin
      same_slot = (ctl_idx == sel_q);
      cancel    = ctl_wr && ctl_req && same_slot && (st_q == PK_WAIT);
      pxfer     = vb_rise && (st_q == PK_WAIT) && !cancel;
      st_d      = st_q;
      sel_d     = sel_q;
      busy_d    = busy_q;
      load      = 1'b0;
      if (pxfer) st_d = PK_IDLE;
      if (ctl_wr) begin
         busy_d = 1'b0;
         unique case (st_q)
            PK_IDLE: begin
               sel_d = ctl_idx;
               if (ctl_req) begin
                  st_d = PK_HELD;
                  load = 1'b1;
               end
            end
            PK_HELD: begin
               if (ctl_req) busy_d = !same_slot;
               else         st_d   = PK_WAIT;
            end
            PK_WAIT: begin
               if (ctl_req) begin
                  if (same_slot) st_d   = PK_HELD;
                  else           busy_d = 1'b1;
               end
            end
            default: st_d = PK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= PK_IDLE;
         sel_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         sel_q  <= sel_d;
         busy_q <= busy_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SLOTS; s++)
            for (int b = 0; b < BYTES; b++) act_q[s][b] <= '0;
         for (int b = 0; b < BYTES; b++) sh_q[b] <= '0;
      end else begin
         if (pxfer)
            for (int b = 0; b < BYTES; b++) act_q[sel_q][b] <= sh_q[b];
         if (load)
            for (int b = 0; b < BYTES; b++) sh_q[b] <= act_q[ctl_idx][b];
         else if (byte_wr && st_q == PK_HELD)
            sh_q[byte_off] <= byte_val;
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
         assign active_flat[(s*BYTES+b)*8 +: 8] = act_q[s][b];
      end
   end
   for (genvar b = 0; b < BYTES; b++) begin : g_sh
      assign shadow_flat[b*8 +: 8] = sh_q[b];
   end

   assign state = st_q;
   assign sel   = sel_q;
   assign busy  = busy_q;
endmodule

// File: rtl/blank_sync_shadow.sv
module blank_sync_shadow
   import bss_pkg::*;
#(
   parameter int NUM_COEF  = 12,
   parameter int COEF_W    = 13,
   parameter int PKT_SLOTS = 4,
   parameter int PKT_BYTES = 8,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int COEF_BASE = 16,
   parameter int PKT_BASE  = 128
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [ADDR_W-1:0]               rd_addr,
   output logic [DATA_W-1:0]               rd_data,
   input  logic                            vblank,
   output logic [NUM_COEF*COEF_W-1:0]      coef_active,
   output logic [1:0]                      csc_scale,
   output logic [PKT_SLOTS*PKT_BYTES*8-1:0] pkt_active,
   output logic                            pkt_busy
);
   localparam int CIDX_W = $clog2(NUM_COEF);
   localparam int SIDX_W = $clog2(PKT_SLOTS);
   localparam int BOFF_W = $clog2(PKT_BYTES);
   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] PKC_ADDR = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] C_LO = ADDR_W'(COEF_BASE);
   localparam logic [ADDR_W-1:0] C_HI = ADDR_W'(COEF_BASE + NUM_COEF);
   localparam logic [ADDR_W-1:0] P_LO = ADDR_W'(PKT_BASE);
   localparam logic [ADDR_W-1:0] P_HI = ADDR_W'(PKT_BASE + PKT_BYTES);

   initial begin
      assert (COEF_W <= DATA_W && DATA_W >= 8)
         else $fatal(1, "data width too narrow");
      assert (NUM_COEF >= 2 && PKT_SLOTS >= 2 && PKT_BYTES >= 2 && SIDX_W <= 5)
         else $fatal(1, "counts out of range");
      assert (COEF_BASE >= 2 && COEF_BASE + NUM_COEF <= PKT_BASE &&
              PKT_BASE + PKT_BYTES < (1 << ADDR_W))
         else $fatal(1, "address regions overlap or overflow");
   end

   logic              vb_rise;
   logic              csc_lock_q, pend_q, pend_d;
   logic [1:0]        scale_q;
   logic              ctl_hit, pkc_hit, coef_hit, byte_hit;
   logic              xfer, lock_fall;
   logic [CIDX_W-1:0] w_cidx, r_cidx;
   logic [BOFF_W-1:0] w_boff, r_boff;
   logic [NUM_COEF*COEF_W-1:0] coef_shadow;
   logic [PKT_BYTES*8-1:0]     pkt_shadow;
   pkt_state_e        pk_state;
   logic [SIDX_W-1:0] pk_sel;

   bss_vblank_edge u_edge (
      .clk     (clk),
      .rst     (rst),
      .vblank  (vblank),
      .vb_rise (vb_rise)
   );

   always_comb begin
      ctl_hit  = wr_en && (wr_addr == CTL_ADDR);
      pkc_hit  = wr_en && (wr_addr == PKC_ADDR);
      coef_hit = wr_en && (wr_addr >= C_LO) && (wr_addr < C_HI);
      byte_hit = wr_en && (wr_addr >= P_LO) && (wr_addr < P_HI);
      w_cidx   = CIDX_W'(wr_addr - C_LO);
      w_boff   = BOFF_W'(wr_addr - P_LO);
      xfer      = vb_rise && pend_q && !csc_lock_q;
      lock_fall = ctl_hit && csc_lock_q && !wr_data[CTL_LOCK_BIT];
      pend_d    = (pend_q && !xfer) || lock_fall || coef_hit;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         csc_lock_q <= 1'b0;
         scale_q    <= 2'b00;
         pend_q     <= 1'b0;
      end else begin
         if (ctl_hit) begin
            csc_lock_q <= wr_data[CTL_LOCK_BIT];
            scale_q    <= wr_data[CTL_SCALE_LO +: 2];
         end
         pend_q <= pend_d;
      end
   end

   bss_coef_bank #(
      .NUM   (NUM_COEF),
      .W     (COEF_W),
      .IDX_W (CIDX_W)
   ) u_coef (
      .clk         (clk),
      .rst         (rst),
      .wr_hit      (coef_hit),
      .wr_idx      (w_cidx),
      .wr_val      (wr_data[COEF_W-1:0]),
      .xfer        (xfer),
      .shadow_flat (coef_shadow),
      .active_flat (coef_active)
   );

   bss_pkt_store #(
      .SLOTS  (PKT_SLOTS),
      .BYTES  (PKT_BYTES),
      .SIDX_W (SIDX_W),
      .BOFF_W (BOFF_W)
   ) u_pkt (
      .clk         (clk),
      .rst         (rst),
      .vb_rise     (vb_rise),
      .ctl_wr      (pkc_hit),
      .ctl_req     (wr_data[PKC_REQ_BIT]),
      .ctl_idx     (wr_data[SIDX_W-1:0]),
      .byte_wr     (byte_hit),
      .byte_off    (w_boff),
      .byte_val    (wr_data[7:0]),
      .active_flat (pkt_active),
      .shadow_flat (pkt_shadow),
      .state       (pk_state),
      .sel         (pk_sel),
      .busy        (pkt_busy)
   );

   assign csc_scale = scale_q;

   always_comb begin
      r_cidx  = CIDX_W'(rd_addr - C_LO);
      r_boff  = BOFF_W'(rd_addr - P_LO);
      rd_data = '0;
      if (rd_addr == CTL_ADDR) begin
         rd_data[CTL_LOCK_BIT]       = csc_lock_q;
         rd_data[CTL_SCALE_LO +: 2]  = scale_q;
         rd_data[CTL_PEND_BIT]       = pend_q;
      end else if (rd_addr == PKC_ADDR) begin
         rd_data[PKC_REQ_BIT]  = (pk_state == PK_HELD);
         rd_data[PKC_BUSY_BIT] = pkt_busy;
         rd_data[PKC_WAIT_BIT] = (pk_state == PK_WAIT);
         rd_data[SIDX_W-1:0]   = pk_sel;
      end else if (rd_addr >= C_LO && rd_addr < C_HI) begin
         rd_data[COEF_W-1:0] = csc_lock_q ? coef_shadow[int'(r_cidx)*COEF_W +: COEF_W]
                                          : coef_active[int'(r_cidx)*COEF_W +: COEF_W];
      end else if (rd_addr >= P_LO && rd_addr < P_HI) begin
         rd_data[7:0] = (pk_state == PK_HELD)
                        ? pkt_shadow[int'(r_boff)*8 +: 8]
                        : pkt_active[(int'(pk_sel)*PKT_BYTES + int'(r_boff))*8 +: 8];
      end
   end
endmodule

// File: rtl/bss_chk.sv
module bss_chk #(
   parameter int CW = 156,
   parameter int PW = 256,
   parameter int AW = 8,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          vblank,
   input logic [CW-1:0] coef_active,
   input logic [1:0]    csc_scale,
   input logic [PW-1:0] pkt_active,
   input logic          pkt_busy,
   input logic          csc_lock_q
);
   logic vb_seen_q;
   logic rise_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         vb_seen_q <= 1'b0;
         rise_q    <= 1'b0;
      end else begin
         vb_seen_q <= vblank;
         rise_q    <= vblank && !vb_seen_q;
      end
   end

   assert_coef_at_blank_R3: assert property (@(posedge clk) disable iff (rst)
      (coef_active != $past(coef_active)) |-> rise_q);

   assert_no_commit_locked_R5: assert property (@(posedge clk) disable iff (rst)
      (coef_active != $past(coef_active)) |-> !$past(csc_lock_q));

   assert_pkt_at_blank_R8: assert property (@(posedge clk) disable iff (rst)
      (pkt_active != $past(pkt_active)) |-> rise_q);

   assert_scale_direct_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == AW'(0)) |=> (csc_scale == $past(wr_data[2:1])));

   assert_busy_cause_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(pkt_busy) |-> $past(wr_en && wr_addr == AW'(1)));
endmodule

bind blank_sync_shadow bss_chk #(
   .CW (NUM_COEF*COEF_W),
   .PW (PKT_SLOTS*PKT_BYTES*8),
   .AW (ADDR_W),
   .DW (DATA_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .vblank      (vblank),
   .coef_active (coef_active),
   .csc_scale   (csc_scale),
   .pkt_active  (pkt_active),
   .pkt_busy    (pkt_busy),
   .csc_lock_q  (csc_lock_q)
);

// File: tb/blank_sync_shadow_tb.sv
`timescale 1ns/100ps
module blank_sync_shadow_tb;
   localparam int NC = 12;
   localparam int CW = 13;
   localparam int PS = 4;
   localparam int PB = 8;
   localparam int AW = 8;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic vblank = 1'b0;
   logic [NC*CW-1:0] coef_active;
   logic [1:0] csc_scale;
   logic [PS*PB*8-1:0] pkt_active;
   logic pkt_busy;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   blank_sync_shadow #(
      .NUM_COEF(NC), .COEF_W(CW), .PKT_SLOTS(PS), .PKT_BYTES(PB),
      .ADDR_W(AW), .DATA_W(DW), .COEF_BASE(16), .PKT_BASE(128)
   ) u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .vblank(vblank),
      .coef_active(coef_active), .csc_scale(csc_scale),
      .pkt_active(pkt_active), .pkt_busy(pkt_busy)
   );

   // ---------------- behavioural reference model ----------------
   int m_cs [NC];
   int m_ca [NC];
   int m_psh [PB];
   int m_pa [PS][PB];
   int m_lock, m_scale, m_pend, m_vbq, m_pst, m_sel, m_busy;

   always @(posedge clk) begin
      if (rst) begin
         foreach (m_cs[i]) begin m_cs[i] = 0; m_ca[i] = 0; end
         foreach (m_psh[b]) m_psh[b] = 0;
         for (int s = 0; s < PS; s++) for (int b = 0; b < PB; b++) m_pa[s][b] = 0;
         m_lock = 0; m_scale = 0; m_pend = 0; m_vbq = 0; m_pst = 0; m_sel = 0; m_busy = 0;
      end else begin
         int a, d, rise, xf, ctl, pkc, cw, pw, np, req, idx, cancel, pxf, nst, nsel, nbusy, ld;
         a = int'(wr_addr); d = int'(wr_data);
         rise = (vblank && !m_vbq); m_vbq = vblank;
         ctl = wr_en && a == 0;
         pkc = wr_en && a == 1;
         cw  = wr_en && a >= 16 && a < 16 + NC;
         pw  = wr_en && a >= 128 && a < 128 + PB;
         xf  = rise && m_pend && !m_lock;
         if (xf) foreach (m_cs[i]) m_ca[i] = m_cs[i];
         if (cw) m_cs[a-16] = d & ((1 << CW) - 1);
         np = (m_pend && !xf) || (ctl && m_lock && !(d & 1)) || cw;
         if (ctl) begin m_lock = d & 1; m_scale = (d >> 1) & 3; end
         m_pend = np;
         req = (d >> 7) & 1; idx = d & 3;
         cancel = pkc && req && idx == m_sel && m_pst == 2;
         pxf = rise && m_pst == 2 && !cancel;
         nst = m_pst; nsel = m_sel; nbusy = m_busy; ld = 0;
         if (pxf) nst = 0;
         if (pkc) begin
            nbusy = 0;
            if (m_pst == 0) begin nsel = idx; if (req) begin nst = 1; ld = 1; end end
            else if (m_pst == 1) begin if (req) nbusy = (idx != m_sel); else nst = 2; end
            else if (req) begin if (idx == m_sel) nst = 1; else nbusy = 1; end
         end
         if (pxf) for (int b = 0; b < PB; b++) m_pa[m_sel][b] = m_psh[b];
         if (ld) for (int b = 0; b < PB; b++) m_psh[b] = m_pa[idx][b];
         else if (pw && m_pst == 1) m_psh[a-128] = d & 255;
         m_pst = nst; m_sel = nsel; m_busy = nbusy;
      end
   end

   function automatic int exp_rd(int a);
      if (a == 0) return m_lock | (m_scale << 1) | (m_pend << 3);
      if (a == 1) return ((m_pst == 1) << 7) | (m_busy << 6) | ((m_pst == 2) << 5) | m_sel;
      if (a >= 16 && a < 16 + NC) return m_lock ? m_cs[a-16] : m_ca[a-16];
      if (a >= 128 && a < 128 + PB) return (m_pst == 1) ? m_psh[a-128] : m_pa[m_sel][a-128];
      return 0;
   endfunction

   task automatic cmp(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // model comparison on every clock, sampled at the falling edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         for (int i = 0; i < NC; i++)
            cmp("R2 R3 R4 R5 R10 model coef", coef_active[i*CW +: CW], m_ca[i]);
         for (int s = 0; s < PS; s++)
            for (int b = 0; b < PB; b++)
               cmp("R8 R11 model pkt", pkt_active[(s*PB+b)*8 +: 8], m_pa[s][b]);
         cmp("R6 model scale", csc_scale, m_scale);
         cmp("R7 model busy", pkt_busy, m_busy);
         cmp("R9 model readback", rd_data, exp_rd(int'(rd_addr)));
      end
   end

   // ---------------- stimulus helpers (called at falling edge) ----------------
   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic vb_pulse();
      vblank = 1'b1;
      @(negedge clk);
      vblank = 1'b0;
      @(negedge clk);
   endtask

   task automatic rdchk(string tag, int a, int exp);
      rd_addr = AW'(a);
      #1;
      cmp(tag, rd_data, exp);
   endtask

   function automatic int coef(int i);
      return int'(coef_active[i*CW +: CW]);
   endfunction

   function automatic int pbyte(int s, int b);
      return int'(pkt_active[(s*PB+b)*8 +: 8]);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      cmp("R1 coef after reset", coef_active, 0);
      cmp("R1 pkt after reset", pkt_active == '0, 1);
      cmp("R1 scale after reset", csc_scale, 0);
      cmp("R1 busy after reset", pkt_busy, 0);
      rdchk("R1 ctrl readback", 0, 0);

      // R2 / R9: locked edits stay in shadow
      wr(0, 1);
      wr(16, 'h123);
      wr(16 + 11, 'h1FFF);
      cmp("R2 coef0 held", coef(0), 0);
      rdchk("R9 shadow readback locked", 16, 'h123);
      vb_pulse();
      cmp("R2 no commit while locked", coef(0), 0);

      // R4: release, then commit at the next vblank rise
      wr(0, 0);
      cmp("R4 no commit before vblank", coef(0), 0);
      rdchk("R9 active readback unlocked", 16, 0);
      vb_pulse();
      cmp("R4 coef0 committed", coef(0), 'h123);
      cmp("R4 coef11 committed", coef(11), 'h1FFF);

      // R5: relock before vblank holds the transfer
      wr(0, 1); wr(17, 'h55); wr(0, 0); wr(0, 1);
      vb_pulse();
      cmp("R5 held by relock", coef(1), 0);
      wr(0, 0);
      vb_pulse();
      cmp("R5 commit after second release", coef(1), 'h55);

      // R6: scale field bypasses shadowing
      wr(0, 'h6);
      cmp("R6 scale immediate unlocked", csc_scale, 3);
      wr(0, 'h3);
      cmp("R6 scale immediate locked", csc_scale, 1);
      wr(0, 'h2);

      // R10: unlocked write waits for blanking
      wr(18, 'h77);
      cmp("R10 unlocked write not yet active", coef(2), 0);
      rdchk("R10 pending bit", 0, 'h8 | 'h2);
      vb_pulse();
      cmp("R10 unlocked write committed", coef(2), 'h77);

      // R7: packet claim and refusal
      wr(1, 'h82);
      cmp("R7 accepted claim not busy", pkt_busy, 0);
      rdchk("R7 claim readback", 1, 'h82);
      wr(1, 'h81);
      cmp("R7 refused claim busy", pkt_busy, 1);
      rdchk("R7 busy readback", 1, 'hC2);

      // R8: packet edits commit at blanking
      wr(128, 'hAB); wr(135, 'hCD);
      rdchk("R9 packet shadow readback", 128, 'hAB);
      cmp("R8 packet held", pbyte(2, 0), 0);
      wr(1, 'h00);
      wr(1, 'h81);
      cmp("R7 refused while transfer waits", pkt_busy, 1);
      vb_pulse();
      cmp("R8 byte0 committed", pbyte(2, 0), 'hAB);
      cmp("R8 byte7 committed", pbyte(2, 7), 'hCD);
      wr(129, 'h99);
      wr(1, 'h02);
      rdchk("R8 write without claim ignored", 129, 0);
      vb_pulse();
      cmp("R8 ignored write not committed", pbyte(2, 1), 0);

      // R11: reclaim cancels waiting transfer
      wr(1, 'h82);
      rdchk("R9 claim loads shadow", 128, 'hAB);
      wr(128, 'h11); wr(1, 'h00); wr(1, 'h82);
      vb_pulse();
      cmp("R11 reclaim cancels transfer", pbyte(2, 0), 'hAB);
      wr(1, 'h00);
      vb_pulse();
      cmp("R11 edits kept for next release", pbyte(2, 0), 'h11);

      // mixed random traffic against the model
      for (int n = 0; n < 6000; n++) begin
         int sel, a;
         sel = $urandom % 7;
         case (sel)
            0: a = 0;
            1: a = 1;
            2, 3: a = 16 + ($urandom % (NC + 1));
            4, 5: a = 128 + ($urandom % (PB + 1));
            default: a = $urandom % 256;
         endcase
         wr_en   = ($urandom % 3) == 0;
         wr_addr = AW'(a);
         wr_data = (a == 1) ? DW'(($urandom & 'h83)) : DW'($urandom);
         vblank  = ($urandom % 5) == 0;
         rd_addr = AW'(($urandom % 2) ? a : ($urandom % 256));
         @(negedge clk);
      end
      wr_en = 1'b0; vblank = 1'b0;
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule